// File: doc/BRIEF.md
# Compact FPU-Condition Branch Resolver

This block resolves the two compact conditional branches that test the least significant bit of a floating-point register. It sits in a simple in-order fetch and execute path. Each cycle it receives an instruction word, the address of that instruction, the 64-bit value of the floating-point register that the instruction names, and a flag saying whether the floating-point coprocessor is enabled. It decodes the word and evaluates the one-bit condition. It then registers four results: a taken flag, the branch target, a squash for the instruction that follows, and a coprocessor-unusable exception.

The block also owns a registered program counter. This counter either advances past the current instruction or loads the branch target. There is no delay slot, so a taken branch kills the next sequential instruction through the squash output. Register-file reads and exception vectoring are done elsewhere. The block resolves a new instruction on every cycle and never stalls, so branches may arrive back to back.

Top module: `fpu_cbranch_resolver`

## Requirements
- R1: A word is a branch only when bits [31:26] equal 6'b010001 and bits [25:21] equal 5'b01000 (branch when bit 0 is clear) or 5'b01001 (branch when bit 0 is set). Bits [20:16] name the register and bits [15:0] hold the offset.
- R2: For subcode 5'b01000 with the coprocessor enabled, the branch is taken exactly when bit 0 of the register value is 0.
- R3: For subcode 5'b01001 with the coprocessor enabled, the branch is taken exactly when bit 0 of the register value is 1. Register bits [63:1] have no effect on the outcome.
- R4: The registered target equals the instruction address plus 4, plus the sign-extended offset shifted left by one bit.
- R5: When a recognised branch is not taken, the program counter becomes the instruction address plus 4.
- R6: When a branch is taken, the outputs taken and squash are both 1 and the program counter becomes the target.
- R7: When the coprocessor-enable flag is 0, a recognised branch raises the coprocessor-unusable output. Taken and squash stay 0, and the program counter becomes the address plus 4.
- R8: A word that is not a recognised branch leaves taken, squash and the exception at 0, and the program counter becomes the address plus 4.
- R9: While rst_ni is low (asynchronous, active low), the program counter holds reset_pc_i and taken, squash and the exception are 0.
- R10: Each cycle resolves a new instruction independently, so consecutive branches are handled with no stall.
- R11: Target and sequential-address arithmetic wrap modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_pc_i | input | 32 | Program counter value loaded on reset |
| instr_i | input | 32 | Instruction word to resolve |
| addr_i | input | 32 | Address of instr_i |
| fpr_val_i | input | 64 | Value of the register selected by the instruction |
| cop_en_i | input | 1 | Floating-point coprocessor enabled |
| taken_o | output | 1 | Branch taken (registered) |
| target_o | output | 32 | Computed branch target (registered) |
| squash_o | output | 1 | Kill the next sequential instruction (registered) |
| cop_unusable_o | output | 1 | Coprocessor-unusable exception (registered) |
| pc_o | output | 32 | Registered program counter |

## Verification
Both subcodes are driven with register values whose bit 0 agrees or disagrees with the tested sense. The upper bits are set opposite to bit 0, which separates a correct single-bit test from a test of any other bit or of the whole value. Offsets of zero-crossing, maximum positive and maximum negative size, plus an address near the top of the space, separate correct sign extension, halfword scaling and the next-address base from off-by-four or unscaled variants, and check modulo wraparound. Near-miss encodings (right major code with a wrong subcode, wrong major code with a right subcode) and disabled-coprocessor cases separate exact decoding and exception priority from loose matching. All of these run on consecutive cycles to cover back-to-back resolution.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam logic [5:0] OP_MAJOR = 6'b010001;
  localparam logic [4:0] SUB_BR_CLR = 5'b01000;
  localparam logic [4:0] SUB_BR_SET = 5'b01001;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_CLR  = 2'd1,
    BR_SET  = 2'd2
  } br_kind_e;
endpackage

// File: rtl/fcb_decode.sv
module fcb_decode
  import fcb_pkg::*;
#(
  parameter int unsigned IW     = 32,
  parameter int unsigned OFFS_W = 16
) (
  input  logic [IW-1:0]     instr_i,
  output br_kind_e          kind_o,
  output logic [OFFS_W-1:0] offs_o
);
  localparam int unsigned OP_LSB  = IW - 6;
  localparam int unsigned SUB_LSB = OP_LSB - 5;

  logic [5:0] op;
  logic [4:0] sub;

  assign op     = instr_i[IW-1:OP_LSB];
  assign sub    = instr_i[OP_LSB-1:SUB_LSB];
  assign offs_o = instr_i[OFFS_W-1:0];

  always_comb begin
    kind_o = BR_NONE;
    if (op == OP_MAJOR) begin
      if (sub == SUB_BR_CLR)      kind_o = BR_CLR;
      else if (sub == SUB_BR_SET) kind_o = BR_SET;
    end
  end
endmodule

// File: rtl/fcb_cond.sv
module fcb_cond
  import fcb_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     lsb_i,
  input  logic     cop_en_i,
  output logic     take_o,
  output logic     exc_o
);
  logic is_br, cond;

  assign is_br  = (kind_i != BR_NONE);
  assign cond   = (kind_i == BR_SET) ? lsb_i : ~lsb_i;
  assign exc_o  = is_br & ~cop_en_i;
  assign take_o = is_br & cop_en_i & cond;
endmodule

// File: rtl/fcb_target.sv
module fcb_target #(
  parameter int unsigned AW     = 32,
  parameter int unsigned OFFS_W = 16
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [AW-1:0]     seq_o,
  output logic [AW-1:0]     tgt_o
);
  localparam int unsigned EXT_W = AW - OFFS_W - 1;

  logic [AW-1:0] disp;

  // halfword-scaled, sign-extended displacement
  assign disp  = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i, 1'b0};
  assign seq_o = addr_i + AW'(4);
  assign tgt_o = seq_o + disp;
endmodule

// File: rtl/fpu_cbranch_resolver.sv
module fpu_cbranch_resolver
  import fcb_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned IW     = 32,
  parameter int unsigned FPR_W  = 64,
  parameter int unsigned OFFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reset_pc_i,
  input  logic [IW-1:0]    instr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [FPR_W-1:0] fpr_val_i,
  input  logic             cop_en_i,
  output logic             taken_o,
  output logic [AW-1:0]    target_o,
  output logic             squash_o,
  output logic             cop_unusable_o,
  output logic [AW-1:0]    pc_o
);
  br_kind_e          kind;
  logic [OFFS_W-1:0] offs;
  logic              take, exc;
  logic [AW-1:0]     seq_addr, tgt_addr;
  logic              unused_fpr_hi;

  // only bit 0 matters, whatever the data format
  assign unused_fpr_hi = ^fpr_val_i[FPR_W-1:1];

  fcb_decode #(.IW(IW), .OFFS_W(OFFS_W)) u_dec (
    .instr_i (instr_i),
    .kind_o  (kind),
    .offs_o  (offs)
  );

  fcb_cond u_cond (
    .kind_i   (kind),
    .lsb_i    (fpr_val_i[0]),
    .cop_en_i (cop_en_i),
    .take_o   (take),
    .exc_o    (exc)
  );

  fcb_target #(.AW(AW), .OFFS_W(OFFS_W)) u_tgt (
    .addr_i (addr_i),
    .offs_i (offs),
    .seq_o  (seq_addr),
    .tgt_o  (tgt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o        <= 1'b0;
      squash_o       <= 1'b0;
      cop_unusable_o <= 1'b0;
      target_o       <= '0;
      pc_o           <= reset_pc_i;
    end else begin
      taken_o        <= take;
      squash_o       <= take;
      cop_unusable_o <= exc;
      target_o       <= tgt_addr;
      pc_o           <= take ? tgt_addr : seq_addr;
    end
  end

  AST_TAKEN_LOADS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (squash_o && pc_o == target_o)); // R6
  AST_EXC_BLOCKS_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_unusable_o |-> (!taken_o && !squash_o)); // R7
  AST_NONBR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == BR_NONE) |=> (!taken_o && !squash_o && !cop_unusable_o)); // R8
  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> (pc_o == $past(addr_i) + AW'(4))); // R5
  AST_TARGET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (target_o == $past(addr_i) + AW'(4)
              + {{(AW-OFFS_W-1){$past(instr_i[OFFS_W-1])}}, $past(instr_i[OFFS_W-1:0]), 1'b0})); // R4
endmodule

// File: tb/fpu_cbranch_resolver_tb_top.sv
module fpu_cbranch_resolver_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] reset_pc_i = 32'hBFC0_0000;
  logic [31:0] instr_i = '0;
  logic [31:0] addr_i = '0;
  logic [63:0] fpr_val_i = '0;
  logic        cop_en_i = 1'b0;
  logic        taken_o, squash_o, cop_unusable_o;
  logic [31:0] target_o, pc_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  fpu_cbranch_resolver dut_i (
    .clk_i, .rst_ni, .reset_pc_i, .instr_i, .addr_i, .fpr_val_i, .cop_en_i,
    .taken_o, .target_o, .squash_o, .cop_unusable_o, .pc_o
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] addr;
    logic [63:0] fpr;
    logic        en;
    logic        tk;
    logic        ex;
    logic [31:0] tgt;
    logic [31:0] pc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h4503_0010, 32'h0000_1000, 64'h0,                    1'b1, 1'b1, 1'b0, 32'h0000_1024, 32'h0000_1024},
    '{32'h4503_0010, 32'h0000_1000, 64'h1,                    1'b1, 1'b0, 1'b0, 32'h0000_1024, 32'h0000_1004},
    '{32'h4525_FFFE, 32'h0000_2000, 64'hFFFF_FFFF_FFFF_FFFF,  1'b1, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_2000},
    '{32'h4525_FFFE, 32'h0000_2000, 64'hFFFF_FFFF_FFFF_FFFE,  1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_2004},
    '{32'h4500_7FFF, 32'h0000_3000, 64'hFFFF_FFFF_FFFF_FFFE,  1'b1, 1'b1, 1'b0, 32'h0001_3002, 32'h0001_3002},
    '{32'h4520_8000, 32'h0002_0000, 64'h1,                    1'b1, 1'b1, 1'b0, 32'h0001_0004, 32'h0001_0004},
    '{32'h4520_0010, 32'hFFFF_FFF8, 64'h1,                    1'b1, 1'b1, 1'b0, 32'h0000_001C, 32'h0000_001C},
    '{32'h4500_0010, 32'h0000_4000, 64'h0,                    1'b0, 1'b0, 1'b1, 32'h0000_4024, 32'h0000_4004},
    '{32'h4520_0010, 32'h0000_4000, 64'h1,                    1'b0, 1'b0, 1'b1, 32'h0000_4024, 32'h0000_4004},
    '{32'h4600_0010, 32'h0000_5000, 64'h0,                    1'b0, 1'b0, 1'b0, 32'h0000_5024, 32'h0000_5004},
    '{32'h0100_0010, 32'h0000_6000, 64'h0,                    1'b0, 1'b0, 1'b0, 32'h0000_6024, 32'h0000_6004},
    '{32'h4540_0010, 32'h0000_7000, 64'h1,                    1'b1, 1'b0, 1'b0, 32'h0000_7024, 32'h0000_7004}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6:       return "R11";
      7, 8:    return "R7";
      9:       return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk_i);
    chk("R9", "pc", pc_o, 32'hBFC0_0000);
    chk("R9", "flags", {29'd0, taken_o, squash_o, cop_unusable_o}, 32'd0);
    rst_ni = 1'b1;

    // table walked on consecutive cycles: R10 back-to-back
    for (int i = 0; i < NV; i++) begin
      instr_i   = VECS[i].instr;
      addr_i    = VECS[i].addr;
      fpr_val_i = VECS[i].fpr;
      cop_en_i  = VECS[i].en;
      @(negedge clk_i);
      chk(req_of(i), "taken", {31'd0, taken_o}, {31'd0, VECS[i].tk});
      chk(req_of(i), "squash R6", {31'd0, squash_o}, {31'd0, VECS[i].tk});
      chk(req_of(i), "exc", {31'd0, cop_unusable_o}, {31'd0, VECS[i].ex});
      chk(req_of(i), "pc R5", pc_o, VECS[i].pc);
      chk(req_of(i), "target R4", target_o, VECS[i].tgt);
    end

    // R10: taken then not-taken on adjacent cycles
    instr_i = 32'h4520_0004; addr_i = 32'h0000_8000; fpr_val_i = 64'h1; cop_en_i = 1'b1;
    @(negedge clk_i);
    chk("R10", "pc first", pc_o, 32'h0000_800C);
    instr_i = 32'h4500_0004; addr_i = 32'h0000_800C; fpr_val_i = 64'h1;
    @(negedge clk_i);
    chk("R10", "taken second", {31'd0, taken_o}, 32'd0);
    chk("R10", "pc second", pc_o, 32'h0000_8010);

    // R9: asynchronous reset mid-cycle after a taken branch
    instr_i = 32'h4500_0004; fpr_val_i = 64'h0;
    @(negedge clk_i);
    chk("R9", "taken pre-reset", {31'd0, taken_o}, 32'd1);
    reset_pc_i = 32'h0000_0100;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R9", "async pc", pc_o, 32'h0000_0100);
    chk("R9", "async flags", {29'd0, taken_o, squash_o, cop_unusable_o}, 32'd0);
    @(negedge clk_i);
    chk("R9", "held pc", pc_o, 32'h0000_0100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule